// File: doc/BRIEF.md
# Banked Internal Data RAM with Bit Addressing

This block is the on-chip data RAM of an 8-bit controller. It holds 128 or 256 bytes and gives three ways in. A register port names one of eight working registers. The controller's status word picks which of four register banks those names refer to. A byte port reaches memory either at a direct address or through a pointer register. A bit port reads, sets or clears single bits in a sixteen-byte flag area.

The lowest 32 bytes hold the four register banks. Each bank is eight bytes long. The bytes just above them form the bit-addressable area. Direct byte addresses at 80h and above belong to the special function registers, which are decoded elsewhere. Such an access only raises a select strobe for that decoder. On the 256-byte build, the upper half of the RAM can be reached only through the pointer registers. On the 128-byte build, a pointer value at or above 80h reaches no storage: a write there is dropped and a read returns 00h.

All read results come out of one shared output, one clock after the request. A flag goes with each result. When more than one port is enabled in the same cycle, a fixed priority lets exactly one of them proceed.

Top module: `bank_iram`

## Requirements
- R1: A register-port access to register n (0..7) while bank b (0..3) is active reaches byte address b*8+n. The active bank is loaded from `sw_bank`, a copy of bits 4:3 of the controller status word, in a cycle where `sw_bank_we` is high.
- R2: After reset, bank 0 is active and no result, select or out-of-range flag is raised. Reset does not alter the stored bytes.
- R3: A direct byte access at 00h..7Fh reads or writes that byte. This includes the registers of banks that are not active; for example, byte 0Ah is register 2 of bank 1.
- R4: A direct byte access at 80h..FFh raises `sfr_sel` for one cycle, one clock after the request. It changes no stored byte and produces no `rd_valid`.
- R5: An indirect byte access (`byte_ind`=1) uses as its address the byte held in register 0 (`byte_ptr`=0) or register 1 (`byte_ptr`=1) of the active bank. On the 256-byte build it reaches all of 00h..FFh.
- R6: Bit address a in 00h..7Fh names bit (a mod 8) of byte 20h + a/8; for example, 5Dh is bit 5 of byte 2Bh. A bit read returns that bit on `rd_bit`.
- R7: A bit write stores `bit_wdata` into only the addressed bit. The other seven bits of that byte and every other byte keep their values. A read in the next cycle sees the new value.
- R8: A bit access at bit address 80h..FFh raises `ext_bit_sel` for one cycle, one clock after the request, changes no stored byte and produces no `rd_valid`.
- R9: Every read that reaches storage raises `rd_valid` exactly one clock after the request, with the byte on `rd_data`. A write or an idle cycle raises nothing.
- R10: When several ports are enabled in the same cycle, the bit port wins over the byte port, and the byte port wins over the register port. A request that loses has no effect at all.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_bank_we | input | 1 | Load the active bank from `sw_bank` |
| sw_bank | input | BW (2) | Status word bits 4:3, the bank number |
| reg_en | input | 1 | Register-port request |
| reg_we | input | 1 | Register-port write (0 = read) |
| reg_num | input | RW (3) | Register number within the active bank |
| reg_wdata | input | 8 | Register-port write data |
| byte_en | input | 1 | Byte-port request |
| byte_we | input | 1 | Byte-port write (0 = read) |
| byte_ind | input | 1 | 1 = indirect through a pointer register, 0 = direct |
| byte_ptr | input | 1 | Pointer choice for indirect access: 0 = register 0, 1 = register 1 |
| byte_addr | input | 8 | Direct byte address |
| byte_wdata | input | 8 | Byte-port write data |
| bit_en | input | 1 | Bit-port request |
| bit_we | input | 1 | Bit-port write (0 = read) |
| bit_addr | input | 8 | Bit address |
| bit_wdata | input | 1 | Value written to the addressed bit |
| rd_valid | output | 1 | Read result present this cycle |
| rd_data | output | 8 | Byte read, or the byte holding the bit that was read |
| rd_bit | output | 1 | Bit read result |
| sfr_sel | output | 1 | A direct access at 80h or above went to the register decoder |
| ext_bit_sel | output | 1 | A bit access fell outside the RAM bit area |

## Verification
The embedded properties rely on two things about the inputs. First, all request inputs are known and are driven only between clock edges. Second, a pointer register is written before any indirect access uses it, because neither the RAM nor the pointer copies are cleared by reset. The bench satisfies both. It drives every input on the falling edge. It fills the whole array, both halves, before the first indirect access: the lower half through direct writes, and the upper half through a bank-3 pointer that is rewritten on the cycle just before each indirect write. The bit-isolation properties also assume that a byte write and a bit write never reach the flag area in the same cycle. The port priority guarantees this, and the bench exercises it by enabling all three ports together.

// File: rtl/iram_pkg.sv
package iram_pkg;
  localparam int DW = 8;
  typedef logic [DW-1:0] byte_t;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_RAM  = 2'd1,
    SRC_BITF = 2'd2,
    SRC_ZERO = 2'd3
  } rsrc_e;

  // One resolved storage request per cycle, after port arbitration.
  typedef struct packed {
    logic       ram_we;   // byte write into the general array
    logic       ram_re;   // byte read from the general array
    logic       bf_we;    // whole-byte write into the flag area
    logic       bf_bwe;   // single-bit write into the flag area
    logic       bf_re;    // read from the flag area
    logic       zero;     // read with no backing storage
    logic       sfr;      // direct access handed to the register decoder
    logic       xbit;     // bit address outside the flag area
    byte_t      addr;     // resolved byte address
    byte_t      wdata;
    logic [2:0] bitpos;
    logic       bitval;
  } mreq_t;
endpackage

// File: rtl/iram_bank_reg.sv
module iram_bank_reg #(
  parameter int BANKS = 4,
  localparam int BW = $clog2(BANKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [BW-1:0] bank_in,
  output logic [BW-1:0] bank
);
  always_ff @(posedge clk) begin
    if (rst)     bank <= '0;
    else if (we) bank <= bank_in;
  end

  // R2: bank 0 is active in the first cycle after reset
  p_bank_reset_r2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> bank == '0);
endmodule

// File: rtl/iram_ptr_shadow.sv
module iram_ptr_shadow
  import iram_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int REGS  = 8,
  localparam int BW   = $clog2(BANKS),
  localparam int PTRS = 2
) (
  input  logic          clk,
  input  logic          wr_en,
  input  byte_t         wr_addr,
  input  byte_t         wr_data,
  input  logic [BW-1:0] bank,
  input  logic          ptr_sel,
  output byte_t         ptr
);
  // Copies of registers 0 and 1 of every bank, so that an indirect
  // access resolves in a single cycle.
  byte_t sh [BANKS][PTRS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < BANKS; b++) begin
        for (int s = 0; s < PTRS; s++) begin
          if (wr_addr == byte_t'(b * REGS + s)) sh[b][s] <= wr_data;
        end
      end
    end
  end

  assign ptr = sh[bank][ptr_sel];
endmodule

// File: rtl/iram_decode.sv
module iram_decode
  import iram_pkg::*;
#(
  parameter int DEPTH      = 256,
  parameter int BANKS      = 4,
  parameter int REGS       = 8,
  parameter int BIT_BASE   = 32,
  parameter int BIT_BYTES  = 16,
  parameter int DIRECT_TOP = 128,
  localparam int BW        = $clog2(BANKS),
  localparam int RW        = $clog2(REGS),
  localparam int BIT_SPAN  = BIT_BYTES * 8
) (
  input  logic [BW-1:0] bank,
  input  byte_t         ptr,
  input  logic          reg_en,
  input  logic          reg_we,
  input  logic [RW-1:0] reg_num,
  input  byte_t         reg_wdata,
  input  logic          byte_en,
  input  logic          byte_we,
  input  logic          byte_ind,
  input  byte_t         byte_addr,
  input  byte_t         byte_wdata,
  input  logic          bit_en,
  input  logic          bit_we,
  input  byte_t         bit_addr,
  input  logic          bit_wdata,
  output mreq_t         req
);
  byte_t reg_addr;
  byte_t tgt, tgt_wd;
  logic  tgt_go, tgt_we;

  assign reg_addr = byte_t'(int'(bank) * REGS + int'(reg_num));

  always_comb begin
    req    = '0;
    tgt    = '0;
    tgt_wd = '0;
    tgt_we = 1'b0;
    tgt_go = 1'b0;
    // Fixed priority: bit port, then byte port, then register port.
    if (bit_en) begin
      if (int'(bit_addr) >= BIT_SPAN) begin
        req.xbit = 1'b1;
      end else begin
        req.addr   = byte_t'(BIT_BASE + int'(bit_addr) / 8);
        req.bitpos = bit_addr[2:0];
        req.bitval = bit_wdata;
        req.bf_bwe = bit_we;
        req.bf_re  = !bit_we;
      end
    end else if (byte_en) begin
      if (!byte_ind && int'(byte_addr) >= DIRECT_TOP) begin
        req.sfr = 1'b1;
      end else begin
        tgt_go = 1'b1;
        tgt    = byte_ind ? ptr : byte_addr;
        tgt_we = byte_we;
        tgt_wd = byte_wdata;
      end
    end else if (reg_en) begin
      tgt_go = 1'b1;
      tgt    = reg_addr;
      tgt_we = reg_we;
      tgt_wd = reg_wdata;
    end

    if (tgt_go) begin
      req.addr  = tgt;
      req.wdata = tgt_wd;
      if (int'(tgt) >= DEPTH) begin
        req.zero = !tgt_we;
      end else if (int'(tgt) >= BIT_BASE && int'(tgt) < BIT_BASE + BIT_BYTES) begin
        req.bf_we = tgt_we;
        req.bf_re = !tgt_we;
      end else begin
        req.ram_we = tgt_we;
        req.ram_re = !tgt_we;
      end
    end
  end
endmodule

// File: rtl/iram_bitfile.sv
module iram_bitfile
  import iram_pkg::*;
#(
  parameter int BYTES = 16,
  localparam int BFW  = $clog2(BYTES)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           byte_we,
  input  logic           bit_we,
  input  logic           rd_en,
  input  logic [BFW-1:0] idx,
  input  byte_t          wdata,
  input  logic [2:0]     bitpos,
  input  logic           bitval,
  output byte_t          rd_q
);
  // Flip-flop storage, so that a bit write is a one-cycle read-modify-write.
  byte_t mem [BYTES];

  always_ff @(posedge clk) begin
    if (byte_we)     mem[idx]         <= wdata;
    else if (bit_we) mem[idx][bitpos] <= bitval;
    if (rd_en) rd_q <= mem[idx];
  end

  // R7: the addressed bit takes the written value
  p_bit_value_r7: assert property (@(posedge clk) disable iff (rst)
    bit_we |=> mem[$past(idx)][$past(bitpos)] == $past(bitval));

  for (genvar k = 0; k < BYTES; k++) begin : g_iso
    // R7: no other bit anywhere in the area moves on a bit write
    p_bit_isolate_r7: assert property (@(posedge clk) disable iff (rst)
      bit_we |=> ((mem[k] ^ $past(mem[k])) &
                  ~(($past(idx) == BFW'(k)) ? (8'h01 << $past(bitpos)) : 8'h00)) == 8'h00);
  end
endmodule

// File: rtl/iram_store.sv
module iram_store
  import iram_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  byte_t         wdata,
  output byte_t         q
);
  // Single-port array with a registered read, suitable for block RAM.
  byte_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) q <= mem[addr];
  end
endmodule

// File: rtl/bank_iram.sv
module bank_iram
  import iram_pkg::*;
#(
  parameter int DEPTH      = 256,
  parameter int BANKS      = 4,
  parameter int REGS       = 8,
  parameter int BIT_BASE   = 32,
  parameter int BIT_BYTES  = 16,
  parameter int DIRECT_TOP = 128,
  localparam int BW        = $clog2(BANKS),
  localparam int RW        = $clog2(REGS),
  localparam int AW        = $clog2(DEPTH),
  localparam int BFW       = $clog2(BIT_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sw_bank_we,
  input  logic [BW-1:0] sw_bank,
  input  logic          reg_en,
  input  logic          reg_we,
  input  logic [RW-1:0] reg_num,
  input  logic [7:0]    reg_wdata,
  input  logic          byte_en,
  input  logic          byte_we,
  input  logic          byte_ind,
  input  logic          byte_ptr,
  input  logic [7:0]    byte_addr,
  input  logic [7:0]    byte_wdata,
  input  logic          bit_en,
  input  logic          bit_we,
  input  logic [7:0]    bit_addr,
  input  logic          bit_wdata,
  output logic          rd_valid,
  output logic [7:0]    rd_data,
  output logic          rd_bit,
  output logic          sfr_sel,
  output logic          ext_bit_sel
);
  logic [BW-1:0]  bank;
  byte_t          ptr;
  mreq_t          req;
  byte_t          ram_q, bf_q;
  logic [BFW-1:0] bf_idx;
  rsrc_e          src_q;
  logic [2:0]     bpos_q;

  iram_bank_reg #(.BANKS(BANKS)) u_bank (
    .clk(clk), .rst(rst), .we(sw_bank_we), .bank_in(sw_bank), .bank(bank)
  );

  iram_ptr_shadow #(.BANKS(BANKS), .REGS(REGS)) u_ptr (
    .clk(clk), .wr_en(req.ram_we), .wr_addr(req.addr), .wr_data(req.wdata),
    .bank(bank), .ptr_sel(byte_ptr), .ptr(ptr)
  );

  iram_decode #(
    .DEPTH(DEPTH), .BANKS(BANKS), .REGS(REGS), .BIT_BASE(BIT_BASE),
    .BIT_BYTES(BIT_BYTES), .DIRECT_TOP(DIRECT_TOP)
  ) u_dec (
    .bank(bank), .ptr(ptr),
    .reg_en(reg_en), .reg_we(reg_we), .reg_num(reg_num), .reg_wdata(reg_wdata),
    .byte_en(byte_en), .byte_we(byte_we), .byte_ind(byte_ind),
    .byte_addr(byte_addr), .byte_wdata(byte_wdata),
    .bit_en(bit_en), .bit_we(bit_we), .bit_addr(bit_addr), .bit_wdata(bit_wdata),
    .req(req)
  );

  assign bf_idx = BFW'(int'(req.addr) - BIT_BASE);

  iram_bitfile #(.BYTES(BIT_BYTES)) u_bits (
    .clk(clk), .rst(rst), .byte_we(req.bf_we), .bit_we(req.bf_bwe),
    .rd_en(req.bf_re), .idx(bf_idx), .wdata(req.wdata),
    .bitpos(req.bitpos), .bitval(req.bitval), .rd_q(bf_q)
  );

  iram_store #(.DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(req.ram_we), .re(req.ram_re), .addr(AW'(req.addr)),
    .wdata(req.wdata), .q(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid    <= 1'b0;
      sfr_sel     <= 1'b0;
      ext_bit_sel <= 1'b0;
      src_q       <= SRC_NONE;
      bpos_q      <= '0;
    end else begin
      rd_valid    <= req.ram_re | req.bf_re | req.zero;
      sfr_sel     <= req.sfr;
      ext_bit_sel <= req.xbit;
      bpos_q      <= req.bitpos;
      if (req.ram_re)     src_q <= SRC_RAM;
      else if (req.bf_re) src_q <= SRC_BITF;
      else if (req.zero)  src_q <= SRC_ZERO;
      else                src_q <= SRC_NONE;
    end
  end

  always_comb begin
    case (src_q)
      SRC_RAM:  rd_data = ram_q;
      SRC_BITF: rd_data = bf_q;
      default:  rd_data = 8'h00;
    endcase
  end

  assign rd_bit = rd_data[bpos_q];

  // R4: a direct access at 80h or above never writes storage
  p_sfr_no_write_r4: assert property (@(posedge clk) disable iff (rst)
    (byte_en && !bit_en && !byte_ind && byte_addr[7]) |->
      !(req.ram_we || req.bf_we || req.bf_bwe));

  // R4 / R8: at most one kind of result flag per cycle
  p_flag_excl_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_valid, sfr_sel, ext_bit_sel}));

  // R9: a read that reaches storage answers exactly one clock later
  p_read_latency_r9: assert property (@(posedge clk) disable iff (rst)
    (req.ram_re || req.bf_re || req.zero) |=> rd_valid);

  // R9: writes and idle cycles raise no result
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (rst)
    !(req.ram_re || req.bf_re || req.zero) |=> !rd_valid);

  // R10: a bit request masks both other ports
  p_bit_wins_r10: assert property (@(posedge clk) disable iff (rst)
    bit_en |-> !(req.ram_we || req.ram_re || req.bf_we || req.sfr || req.zero));
endmodule

// File: tb/bank_iram_test.sv
`timescale 1ns/1ps
module bank_iram_test;
  localparam int K_BYTE = 0;
  localparam int K_BIT  = 1;
  localparam int K_SFR  = 2;
  localparam int K_XBIT = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sw_bank_we = 1'b0;
  logic [1:0] sw_bank = '0;
  logic       reg_en = 1'b0, reg_we = 1'b0;
  logic [2:0] reg_num = '0;
  logic [7:0] reg_wdata = '0;
  logic       byte_en = 1'b0, byte_we = 1'b0, byte_ind = 1'b0, byte_ptr = 1'b0;
  logic [7:0] byte_addr = '0, byte_wdata = '0;
  logic       bit_en = 1'b0, bit_we = 1'b0, bit_wdata = 1'b0;
  logic [7:0] bit_addr = '0;
  logic       rd_valid, rd_bit, sfr_sel, ext_bit_sel;
  logic [7:0] rd_data;

  bank_iram uut (
    .clk(clk), .rst(rst), .sw_bank_we(sw_bank_we), .sw_bank(sw_bank),
    .reg_en(reg_en), .reg_we(reg_we), .reg_num(reg_num), .reg_wdata(reg_wdata),
    .byte_en(byte_en), .byte_we(byte_we), .byte_ind(byte_ind), .byte_ptr(byte_ptr),
    .byte_addr(byte_addr), .byte_wdata(byte_wdata),
    .bit_en(bit_en), .bit_we(bit_we), .bit_addr(bit_addr), .bit_wdata(bit_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_bit(rd_bit),
    .sfr_sel(sfr_sel), .ext_bit_sel(ext_bit_sel)
  );

  always #4 clk = ~clk;  // 125 MHz

  typedef struct {
    int         kind;
    logic [7:0] data;
    int         cyc;
    int         rq;
  } exp_t;

  exp_t       sb[$];
  logic [7:0] m [256];
  int         bank_m = 0;
  int         cyc = 0;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input int rq, input string what,
                     input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, got, exp);
    end
  endtask

  task automatic push(input int kind, input logic [7:0] data, input int rq);
    exp_t e;
    e.kind = kind; e.data = data; e.cyc = cyc; e.rq = rq;
    sb.push_back(e);
  endtask

  // Monitor: pops one expected item for every flag the design raises.
  always @(negedge clk) begin
    if (!rst && (rd_valid || sfr_sel || ext_bit_sel)) begin
      int obs;
      exp_t e;
      obs = sfr_sel ? K_SFR : ext_bit_sel ? K_XBIT : K_BYTE;
      if (sb.size() == 0) begin
        chk(1'b0, 9, "unexpected result", obs, -1);  // R9
      end else begin
        e = sb.pop_front();
        // R9: result one clock after issue
        chk(cyc == e.cyc + 1, 9, "latency", cyc - e.cyc, 1);
        if (e.kind == K_BIT)
          chk(obs == K_BYTE && rd_bit == e.data[0], e.rq, "bit result",
              {obs, 7'b0, rd_bit}, e.data[0]);
        else if (e.kind == K_BYTE)
          chk(obs == K_BYTE && rd_data == e.data, e.rq, "byte result",
              rd_data, e.data);
        else
          chk(obs == e.kind, e.rq, "flag kind", obs, e.kind);
      end
    end
  end

  task automatic clr();
    sw_bank_we = 1'b0; reg_en = 1'b0; reg_we = 1'b0; byte_en = 1'b0;
    byte_we = 1'b0; byte_ind = 1'b0; bit_en = 1'b0; bit_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); clr(); end
  endtask

  task automatic set_bank(input int b);
    @(negedge clk); clr();
    sw_bank_we = 1'b1; sw_bank = 2'(b); bank_m = b;
  endtask

  task automatic wr_dir(input int a, input logic [7:0] d);
    @(negedge clk); clr();
    byte_en = 1'b1; byte_we = 1'b1; byte_addr = 8'(a); byte_wdata = d;
    if (a < 128) m[a] = d; else push(K_SFR, 8'h00, 4);
  endtask

  task automatic rd_dir(input int a, input int rq);
    @(negedge clk); clr();
    byte_en = 1'b1; byte_addr = 8'(a);
    if (a < 128) push(K_BYTE, m[a], rq); else push(K_SFR, 8'h00, rq);
  endtask

  task automatic wr_ind(input bit ps, input logic [7:0] d);
    @(negedge clk); clr();
    byte_en = 1'b1; byte_we = 1'b1; byte_ind = 1'b1; byte_ptr = ps; byte_wdata = d;
    m[m[bank_m * 8 + int'(ps)]] = d;
  endtask

  task automatic rd_ind(input bit ps, input int rq);
    @(negedge clk); clr();
    byte_en = 1'b1; byte_ind = 1'b1; byte_ptr = ps;
    push(K_BYTE, m[m[bank_m * 8 + int'(ps)]], rq);
  endtask

  task automatic wr_reg(input int n, input logic [7:0] d);
    @(negedge clk); clr();
    reg_en = 1'b1; reg_we = 1'b1; reg_num = 3'(n); reg_wdata = d;
    m[bank_m * 8 + n] = d;
  endtask

  task automatic rd_reg(input int n, input int rq);
    @(negedge clk); clr();
    reg_en = 1'b1; reg_num = 3'(n);
    push(K_BYTE, m[bank_m * 8 + n], rq);
  endtask

  task automatic wr_bit(input int ba, input bit v);
    @(negedge clk); clr();
    bit_en = 1'b1; bit_we = 1'b1; bit_addr = 8'(ba); bit_wdata = v;
    if (ba < 128) m[32 + ba / 8][ba % 8] = v; else push(K_XBIT, 8'h00, 8);
  endtask

  task automatic rd_bitp(input int ba, input int rq);
    @(negedge clk); clr();
    bit_en = 1'b1; bit_addr = 8'(ba);
    if (ba < 128) push(K_BIT, {7'b0, m[32 + ba / 8][ba % 8]}, rq);
    else push(K_XBIT, 8'h00, rq);
  endtask

  task automatic do_reset();
    @(negedge clk); clr(); rst = 1'b1;
    idle(3);
    @(negedge clk); rst = 1'b0; bank_m = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R2: reset state of the outputs
    chk(!rd_valid && !sfr_sel && !ext_bit_sel, 2, "flags after reset",
        {rd_valid, sfr_sel, ext_bit_sel}, 0);

    // Fill the lower half directly.
    for (int a = 0; a < 128; a++) wr_dir(a, 8'((a * 37 + 11) & 8'hFF));
    // Fill the upper half through register 1 of bank 3 (byte 19h). R5
    set_bank(3);
    for (int a = 128; a < 256; a++) begin
      wr_dir(8'h19, 8'(a));
      wr_ind(1'b1, 8'((a * 13) ^ 8'hA5));
    end

    // R3: direct reads, including an inactive bank register
    rd_dir(8'h0A, 3);
    rd_dir(8'h00, 3);
    rd_dir(8'h7F, 3);
    rd_dir(8'h45, 3);

    // R1: register names map through the bank select
    set_bank(1);
    rd_reg(2, 1);           // byte 0Ah
    set_bank(2);
    wr_reg(5, 8'hC3);       // byte 15h
    rd_dir(8'h15, 1);
    rd_reg(7, 1);
    set_bank(0);
    rd_reg(4, 1);

    // R5: indirect through register 0 and register 1 of the active bank
    wr_reg(0, 8'h9C);
    wr_reg(1, 8'h2B);
    rd_ind(1'b0, 5);
    rd_ind(1'b1, 5);
    set_bank(2);
    wr_reg(0, 8'hFF);
    rd_ind(1'b0, 5);
    wr_ind(1'b0, 8'h3E);
    rd_ind(1'b0, 5);

    // R4: direct access at 80h and above goes to the register decoder
    rd_dir(8'h80, 4);
    rd_dir(8'hFF, 4);
    wr_dir(8'h9C, 8'h00);
    set_bank(0);
    rd_ind(1'b0, 4);        // byte 9Ch through register 0 of bank 0: unchanged

    // R6: bit address mapping
    rd_bitp(8'h5D, 6);      // bit 5 of byte 2Bh
    rd_bitp(8'h00, 6);
    rd_bitp(8'h37, 6);      // bit 7 of byte 26h
    rd_bitp(8'h7F, 6);

    // R7: set and clear single bits, then read back whole bytes
    wr_bit(8'h5D, ~m[8'h2B][5]);
    rd_bitp(8'h5D, 7);
    rd_dir(8'h2B, 7);
    wr_bit(8'h40, 1'b1);
    wr_bit(8'h47, 1'b0);
    rd_dir(8'h28, 7);
    rd_dir(8'h27, 7);
    rd_dir(8'h29, 7);

    // R8: bit addresses outside the area
    rd_bitp(8'hE7, 8);
    wr_bit(8'hE7, ~m[8'h2C][7]);
    wr_bit(8'h80, ~m[8'h20][0]);
    rd_dir(8'h2C, 8);
    rd_dir(8'h20, 8);
    rd_dir(8'h2F, 8);

    // R10: all three ports at once; only the bit read proceeds
    @(negedge clk); clr();
    bit_en = 1'b1; bit_addr = 8'h12;
    byte_en = 1'b1; byte_we = 1'b1; byte_addr = 8'h50; byte_wdata = ~m[8'h50];
    reg_en = 1'b1; reg_we = 1'b1; reg_num = 3'd3; reg_wdata = ~m[3];
    push(K_BIT, {7'b0, m[32 + 2][2]}, 10);
    // byte read against a register write; only the byte read proceeds
    @(negedge clk); clr();
    byte_en = 1'b1; byte_addr = 8'h51;
    reg_en = 1'b1; reg_we = 1'b1; reg_num = 3'd6; reg_wdata = ~m[6];
    push(K_BYTE, m[8'h51], 10);
    rd_dir(8'h50, 10);
    rd_dir(8'h03, 10);
    rd_dir(8'h06, 10);

    // R2: reset keeps contents and returns to bank 0
    set_bank(3);
    do_reset();
    rd_reg(3, 2);           // byte 03h
    rd_dir(8'h2B, 2);
    rd_ind(1'b0, 2);

    // R9: back-to-back reads on mixed ports
    rd_dir(8'h10, 9);
    rd_bitp(8'h21, 9);
    rd_reg(0, 9);
    rd_ind(1'b1, 9);

    idle(4);
    chk(sb.size() == 0, 9, "results outstanding", sb.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule